// File: doc/BRIEF.md
# Byte-Load Execution Unit

This unit runs the 8-bit load group of a classic accumulator-style processor. It pulls opcode bytes one at a time through a request/acknowledge fetch port. Register-to-register moves, immediate loads, loads through the H:L pointer and indexed loads are carried out in a register file of seven byte registers. An indexed load names one of two 16-bit base registers with a one-byte prefix and adds a signed displacement byte to it. Memory operands come back through a separate request/acknowledge read port.

Each register write is reported one cycle later on a write-back strobe, together with the 3-bit register code and the value. Any opcode outside the group raises a one-cycle illegal strobe, and the unit then goes on with the next byte. The stop opcode parks the unit until reset. The base registers take parameterised reset values, which are zero by default, and no instruction in this group writes them.

Top module: `ldx_load_unit`

## Requirements
- R1: After reset the byte registers read as zero, the fetch address is RESET_PC, fetch_req_o is high, and mem_req_o, wr_valid_o, illegal_o and halted_o are low.
- R2: A byte 01 ddd sss, with neither field equal to 110, copies register sss into register ddd. The codes are B=000, C=001, D=010, E=011, H=100, L=101, A=111. One cycle after the byte is accepted, wr_valid_o is high with wr_code_o=ddd and the copied value.
- R3: A byte 00 ddd 110, with ddd not 110, writes the next fetched byte into register ddd.
- R4: A byte 01 ddd 110, with ddd not 110, issues a memory read at address {H,L} and writes the returned byte into ddd. The write is reported one cycle after the read is acknowledged.
- R5: The prefix 0xDD (base X) or 0xFD (base Y), followed by 01 ddd 110 and then a byte d, reads memory at base + sign-extended d modulo 2^16 into ddd.
- R6: While a request is pending and not acknowledged, the request, its address and the unit state are held. The fetch address advances by one for every accepted byte.
- R7: Byte 0x00 writes nothing, raises no strobe and fetches the next byte.
- R8: Byte 0x76 sets halted_o from the next cycle and stops all requests until reset.
- R9: Any other opcode, including 0x36 and the stores 0x70 to 0x75 and 0x77, pulses illegal_o for one cycle, writes nothing, and fetching continues at the following byte.
- R10: A prefix followed by a byte not of the form 01 ddd 110 with ddd not 110 (0x76 included) pulses illegal_o. The unit then treats the byte after it as an opcode.
- R11: fetch_req_o and mem_req_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_o | output | 1 | Instruction byte wanted |
| fetch_addr_o | output | ADDR_W | Address of the wanted byte |
| fetch_ack_i | input | 1 | Byte on fetch_data_i is valid this cycle |
| fetch_data_i | input | DATA_W | Fetched byte |
| mem_req_o | output | 1 | Data read wanted |
| mem_addr_o | output | ADDR_W | Data read address |
| mem_ack_i | input | 1 | Byte on mem_data_i is valid this cycle |
| mem_data_i | input | DATA_W | Data byte read |
| wr_valid_o | output | 1 | A register was written in the previous cycle |
| wr_code_o | output | 3 | Code of the written register |
| wr_data_o | output | DATA_W | Value written |
| illegal_o | output | 1 | One-cycle pulse for an unsupported byte |
| halted_o | output | 1 | Stop opcode executed |

## Verification
A register write, an illegal pulse and the halted flag all appear in the cycle that follows the rising edge that accepted the deciding byte. A memory request appears in the cycle after the last instruction byte is accepted and stays up until it is acknowledged. The bench advances a behavioural model on every rising edge, using only the acknowledges it drove itself. It compares every output against that model at the following falling edge, so each result is checked in exactly the cycle it is due. Two acknowledge patterns are used: one with random stalls and one with no stalls.

// File: rtl/ldx_pkg.sv
`timescale 1ns/1ps
package ldx_pkg;

   localparam int unsigned CODE_W    = 3;
   localparam int unsigned NUM_SLOTS = 1 << CODE_W;

   // register code that stands for the memory operand, never a register
   localparam logic [CODE_W-1:0] CODE_MEM = 3'b110;
   localparam logic [CODE_W-1:0] CODE_H   = 3'b100;
   localparam logic [CODE_W-1:0] CODE_L   = 3'b101;

   localparam logic [7:0] OPC_NOP   = 8'h00;
   localparam logic [7:0] OPC_STOP  = 8'h76;
   localparam logic [7:0] OPC_PFX_X = 8'hDD;
   localparam logic [7:0] OPC_PFX_Y = 8'hFD;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_IMM,
      ST_PFX,
      ST_DISP,
      ST_MEM,
      ST_HALT
   } ldx_state_e;

   typedef enum logic [2:0] {
      OP_NOP,
      OP_HALT,
      OP_PFX,
      OP_MOVE,
      OP_IMM,
      OP_MEMRD,
      OP_BAD
   } ldx_kind_e;

   typedef struct packed {
      ldx_kind_e         kind;
      logic              base_y;
      logic [CODE_W-1:0] dst;
      logic [CODE_W-1:0] src;
   } ldx_dec_t;

endpackage

// File: rtl/ldx_decoder.sv
`timescale 1ns/1ps
module ldx_decoder
   import ldx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic              after_pfx_i,
   output ldx_dec_t          dec_o
);

   logic [CODE_W-1:0] dst_fld;
   logic [CODE_W-1:0] src_fld;
   logic              grp_move;
   logic              grp_imm;
   logic              dst_is_reg;
   logic              src_is_mem;

   assign dst_fld    = byte_i[5:3];
   assign src_fld    = byte_i[2:0];
   assign grp_move   = (byte_i[7:6] == 2'b01);
   assign grp_imm    = (byte_i[7:6] == 2'b00);
   assign dst_is_reg = (dst_fld != CODE_MEM);
   assign src_is_mem = (src_fld == CODE_MEM);

   always_comb begin
      dec_o.dst    = dst_fld;
      dec_o.src    = src_fld;
      dec_o.base_y = byte_i[5];
      dec_o.kind   = OP_BAD;
      if (after_pfx_i) begin
         if (grp_move && dst_is_reg && src_is_mem) begin
            dec_o.kind = OP_MEMRD;
         end
      end else if (byte_i == OPC_NOP) begin
         dec_o.kind = OP_NOP;
      end else if (byte_i == OPC_STOP) begin
         dec_o.kind = OP_HALT;
      end else if (byte_i == OPC_PFX_X || byte_i == OPC_PFX_Y) begin
         dec_o.kind = OP_PFX;
      end else if (grp_move && dst_is_reg) begin
         dec_o.kind = src_is_mem ? OP_MEMRD : OP_MOVE;
      end else if (grp_imm && dst_is_reg && src_is_mem) begin
         dec_o.kind = OP_IMM;
      end
   end

endmodule

// File: rtl/ldx_regfile.sv
`timescale 1ns/1ps
module ldx_regfile
   import ldx_pkg::*;
#(
   parameter int unsigned        DATA_W  = 8,
   parameter int unsigned        ADDR_W  = 16,
   parameter logic [ADDR_W-1:0]  IX_INIT = '0,
   parameter logic [ADDR_W-1:0]  IY_INIT = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [CODE_W-1:0] wcode_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CODE_W-1:0] rcode_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] hl_o,
   output logic [ADDR_W-1:0] ix_o,
   output logic [ADDR_W-1:0] iy_o
);

   logic [DATA_W-1:0] slot [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      if (g == int'(CODE_MEM)) begin : g_hole
         assign slot[g] = '0;
      end else begin : g_reg
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               val_q <= '0;
            end else if (we_i && (wcode_i == CODE_W'(g))) begin
               val_q <= wdata_i;
            end
         end
         assign slot[g] = val_q;
      end
   end

   logic [ADDR_W-1:0] ix_q;
   logic [ADDR_W-1:0] iy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ix_q <= IX_INIT;
         iy_q <= IY_INIT;
      end else begin
         ix_q <= ix_q;
         iy_q <= iy_q;
      end
   end

   assign rdata_o = slot[rcode_i];
   assign hl_o    = {slot[CODE_H], slot[CODE_L]};
   assign ix_o    = ix_q;
   assign iy_o    = iy_q;

endmodule

// File: rtl/ldx_addr_gen.sv
`timescale 1ns/1ps
module ldx_addr_gen #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 16
) (
   input  logic              base_y_i,
   input  logic [ADDR_W-1:0] ix_i,
   input  logic [ADDR_W-1:0] iy_i,
   input  logic [DATA_W-1:0] disp_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned EXT_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offs;

   assign base = base_y_i ? iy_i : ix_i;

   if (EXT_W > 0) begin : g_sext
      assign offs = {{EXT_W{disp_i[DATA_W-1]}}, disp_i};
   end else begin : g_trunc
      assign offs = disp_i[ADDR_W-1:0];
   end

   // carry out of the top bit is dropped: modulo 2^ADDR_W
   assign addr_o = base + offs;

endmodule

// File: rtl/ldx_load_unit.sv
`timescale 1ns/1ps
module ldx_load_unit
   import ldx_pkg::*;
#(
   parameter int unsigned        DATA_W   = 8,
   parameter int unsigned        ADDR_W   = 16,
   parameter logic [ADDR_W-1:0]  RESET_PC = '0,
   parameter logic [ADDR_W-1:0]  IX_INIT  = '0,
   parameter logic [ADDR_W-1:0]  IY_INIT  = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   output logic              fetch_req_o,
   output logic [ADDR_W-1:0] fetch_addr_o,
   input  logic              fetch_ack_i,
   input  logic [DATA_W-1:0] fetch_data_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              wr_valid_o,
   output logic [2:0]        wr_code_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              illegal_o,
   output logic              halted_o
);

   if (DATA_W != 8) begin : g_chk_dw
      $error("ldx_load_unit: opcodes are bytes, DATA_W must be 8");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_chk_aw
      $error("ldx_load_unit: ADDR_W must equal two register widths");
   end
   if (CODE_W != 3) begin : g_chk_cw
      $error("ldx_load_unit: register code must be 3 bits");
   end

   ldx_state_e        state_q, state_d;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] maddr_q, maddr_d;
   logic [CODE_W-1:0] dst_q, dst_d;
   logic              base_y_q, base_y_d;

   logic              fetch_req, fetch_fire;
   logic              mem_req, mem_fire;
   ldx_dec_t          dec;

   logic              rf_we;
   logic [CODE_W-1:0] rf_wcode;
   logic [DATA_W-1:0] rf_wdata;
   logic [DATA_W-1:0] rf_rdata;
   logic [ADDR_W-1:0] hl, ix, iy, idx_addr;
   logic              bad_d;

   logic              wr_valid_q, ill_q;
   logic [CODE_W-1:0] wr_code_q;
   logic [DATA_W-1:0] wr_data_q;

   assign fetch_req  = (state_q == ST_OPC) || (state_q == ST_IMM) ||
                       (state_q == ST_PFX) || (state_q == ST_DISP);
   assign fetch_fire = fetch_req && fetch_ack_i;
   assign mem_req    = (state_q == ST_MEM);
   assign mem_fire   = mem_req && mem_ack_i;

   ldx_decoder #(
      .DATA_W      (DATA_W)
   ) dec_i (
      .byte_i      (fetch_data_i),
      .after_pfx_i (state_q == ST_PFX),
      .dec_o       (dec)
   );

   ldx_regfile #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .IX_INIT (IX_INIT),
      .IY_INIT (IY_INIT)
   ) rf_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (rf_we),
      .wcode_i (rf_wcode),
      .wdata_i (rf_wdata),
      .rcode_i (dec.src),
      .rdata_o (rf_rdata),
      .hl_o    (hl),
      .ix_o    (ix),
      .iy_o    (iy)
   );

   ldx_addr_gen #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) agen_i (
      .base_y_i (base_y_q),
      .ix_i     (ix),
      .iy_i     (iy),
      .disp_i   (fetch_data_i),
      .addr_o   (idx_addr)
   );

   always_comb begin
      state_d  = state_q;
      dst_d    = dst_q;
      base_y_d = base_y_q;
      maddr_d  = maddr_q;
      rf_we    = 1'b0;
      rf_wcode = dst_q;
      rf_wdata = fetch_data_i;
      bad_d    = 1'b0;
      case (state_q)
         ST_OPC: begin
            if (fetch_fire) begin
               case (dec.kind)
                  OP_NOP: ;
                  OP_HALT: state_d = ST_HALT;
                  OP_PFX: begin
                     base_y_d = dec.base_y;
                     state_d  = ST_PFX;
                  end
                  OP_MOVE: begin
                     rf_we    = 1'b1;
                     rf_wcode = dec.dst;
                     rf_wdata = rf_rdata;
                  end
                  OP_IMM: begin
                     dst_d   = dec.dst;
                     state_d = ST_IMM;
                  end
                  OP_MEMRD: begin
                     dst_d   = dec.dst;
                     maddr_d = hl;
                     state_d = ST_MEM;
                  end
                  default: bad_d = 1'b1;
               endcase
            end
         end
         ST_IMM: begin
            if (fetch_fire) begin
               rf_we   = 1'b1;
               state_d = ST_OPC;
            end
         end
         ST_PFX: begin
            if (fetch_fire) begin
               if (dec.kind == OP_MEMRD) begin
                  dst_d   = dec.dst;
                  state_d = ST_DISP;
               end else begin
                  bad_d   = 1'b1;
                  state_d = ST_OPC;
               end
            end
         end
         ST_DISP: begin
            if (fetch_fire) begin
               maddr_d = idx_addr;
               state_d = ST_MEM;
            end
         end
         ST_MEM: begin
            if (mem_fire) begin
               rf_we    = 1'b1;
               rf_wdata = mem_data_i;
               state_d  = ST_OPC;
            end
         end
         ST_HALT: ;
         default: state_d = ST_OPC;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_OPC;
         pc_q       <= RESET_PC;
         maddr_q    <= '0;
         dst_q      <= '0;
         base_y_q   <= 1'b0;
         wr_valid_q <= 1'b0;
         wr_code_q  <= '0;
         wr_data_q  <= '0;
         ill_q      <= 1'b0;
      end else begin
         state_q    <= state_d;
         maddr_q    <= maddr_d;
         dst_q      <= dst_d;
         base_y_q   <= base_y_d;
         wr_valid_q <= rf_we;
         wr_code_q  <= rf_wcode;
         wr_data_q  <= rf_wdata;
         ill_q      <= bad_d;
         if (fetch_fire) begin
            pc_q <= pc_q + 1'b1;
         end
      end
   end

   assign fetch_req_o  = fetch_req;
   assign fetch_addr_o = pc_q;
   assign mem_req_o    = mem_req;
   assign mem_addr_o   = maddr_q;
   assign wr_valid_o   = wr_valid_q;
   assign wr_code_o    = wr_code_q;
   assign wr_data_o    = wr_data_q;
   assign illegal_o    = ill_q;
   assign halted_o     = (state_q == ST_HALT);

   // R6
   fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_addr_o));

   // R6
   pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fetch_req_o && fetch_ack_i |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);

   // R6
   mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

   // R11
   req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(fetch_req_o && mem_req_o));

   // R8
   halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halted_o |=> halted_o && !fetch_req_o && !mem_req_o);

   // R4
   mem_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && mem_ack_i |=> wr_valid_o && wr_data_o == $past(mem_data_i));

   // R9
   ill_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> !wr_valid_o);

   // R2
   wb_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_o |-> wr_code_o != CODE_MEM);

   // R7
   nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_OPC && fetch_fire && fetch_data_i == OPC_NOP
      |=> !wr_valid_o && !illegal_o && fetch_req_o);

endmodule

// File: tb/ldx_load_unit_tb_top.sv
`timescale 1ns/1ps
module ldx_load_unit_tb_top;

   localparam logic [15:0] IXV = 16'h1230;
   localparam logic [15:0] IYV = 16'hFFF8;
   localparam int M_OPC = 0, M_IMM = 1, M_PFX = 2, M_DISP = 3, M_MEM = 4, M_HALT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req_o, mem_req_o, wr_valid_o, illegal_o, halted_o;
   logic [15:0] fetch_addr_o, mem_addr_o;
   logic        fetch_ack_i = 1'b0;
   logic        mem_ack_i = 1'b0;
   logic [7:0]  fetch_data_i, mem_data_i, wr_data_o;
   logic [2:0]  wr_code_o;

   logic [7:0]  prog [64];
   int          n_chk = 0;
   int          n_err = 0;
   int          cyc = 0;
   bit          chk_en = 1'b0;
   bit          ack_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   function automatic logic [7:0] memf(logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   assign fetch_data_i = prog[fetch_addr_o[5:0]];
   assign mem_data_i   = memf(mem_addr_o);

   ldx_load_unit #(
      .DATA_W       (8),
      .ADDR_W       (16),
      .RESET_PC     (16'h0000),
      .IX_INIT      (IXV),
      .IY_INIT      (IYV)
   ) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .fetch_req_o  (fetch_req_o),
      .fetch_addr_o (fetch_addr_o),
      .fetch_ack_i  (fetch_ack_i),
      .fetch_data_i (fetch_data_i),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_ack_i    (mem_ack_i),
      .mem_data_i   (mem_data_i),
      .wr_valid_o   (wr_valid_o),
      .wr_code_o    (wr_code_o),
      .wr_data_o    (wr_data_o),
      .illegal_o    (illegal_o),
      .halted_o     (halted_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_st;
   logic [15:0] m_pc, m_addr, m_base;
   logic [7:0]  m_r [8];
   logic [2:0]  m_dst;
   string       m_mtag;
   bit          e_wr, e_ill;
   logic [2:0]  e_code;
   logic [7:0]  e_data;
   string       e_tag, i_tag;

   task automatic model_reset();
      m_st = M_OPC; m_pc = 16'h0000; m_addr = 16'h0000;
      for (int i = 0; i < 8; i++) m_r[i] = 8'h00;
      e_wr = 1'b0; e_ill = 1'b0; e_code = 3'd0; e_data = 8'h00;
      e_tag = "R1"; i_tag = "R1"; m_mtag = "R4";
   endtask

   always @(posedge clk) begin
      logic [7:0] b;
      if (!rst_n) begin
         model_reset();
      end else begin
         e_wr = 1'b0; e_ill = 1'b0; e_tag = "R2"; i_tag = "R9";
         if (m_st == M_MEM) begin
            if (mem_ack_i) begin
               e_wr = 1'b1; e_code = m_dst; e_data = memf(m_addr); e_tag = m_mtag;
               m_r[m_dst] = e_data; m_st = M_OPC;
            end
         end else if (m_st != M_HALT && fetch_ack_i) begin
            b = prog[m_pc[5:0]];
            m_pc = m_pc + 16'd1;
            case (m_st)
               M_OPC: begin
                  if (b == 8'h00) e_tag = "R7";
                  else if (b == 8'h76) m_st = M_HALT;
                  else if (b == 8'hDD) begin m_base = IXV; m_st = M_PFX; end
                  else if (b == 8'hFD) begin m_base = IYV; m_st = M_PFX; end
                  else if (b[7:6] == 2'b01 && b[5:3] != 3'b110) begin
                     if (b[2:0] == 3'b110) begin
                        m_dst = b[5:3]; m_addr = {m_r[4], m_r[5]}; m_mtag = "R4"; m_st = M_MEM;
                     end else begin
                        e_wr = 1'b1; e_code = b[5:3]; e_data = m_r[b[2:0]];
                        m_r[b[5:3]] = e_data;
                     end
                  end else if (b[7:6] == 2'b00 && b[2:0] == 3'b110 && b[5:3] != 3'b110) begin
                     m_dst = b[5:3]; m_st = M_IMM;
                  end else begin
                     e_ill = 1'b1;
                  end
               end
               M_IMM: begin
                  e_wr = 1'b1; e_code = m_dst; e_data = b; e_tag = "R3";
                  m_r[m_dst] = b; m_st = M_OPC;
               end
               M_PFX: begin
                  if (b[7:6] == 2'b01 && b[2:0] == 3'b110 && b[5:3] != 3'b110) begin
                     m_dst = b[5:3]; m_st = M_DISP;
                  end else begin
                     e_ill = 1'b1; i_tag = "R10"; m_st = M_OPC;
                  end
               end
               default: begin
                  m_addr = m_base + {{8{b[7]}}, b}; m_mtag = "R5"; m_st = M_MEM;
               end
            endcase
         end
      end
   end

   // ---------------- logs for directed checks ----------------
   logic [15:0] ma_log [$];
   logic [10:0] wr_log [$];

   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req_o && mem_ack_i) ma_log.push_back(mem_addr_o);
         if (wr_valid_o) wr_log.push_back({wr_code_o, wr_data_o});
      end
   end

   // ---------------- per-cycle compare, then drive acks ----------------
   always @(negedge clk) begin
      if (rst_n && chk_en) begin
         chk(fetch_req_o == (m_st <= M_DISP), "R6", "fetch_req_o", 32'(fetch_req_o), 32'(m_st <= M_DISP));
         chk(fetch_addr_o == m_pc, "R6", "fetch_addr_o", 32'(fetch_addr_o), 32'(m_pc));
         chk(mem_req_o == (m_st == M_MEM), m_mtag, "mem_req_o", 32'(mem_req_o), 32'(m_st == M_MEM));
         if (m_st == M_MEM)
            chk(mem_addr_o == m_addr, m_mtag, "mem_addr_o", 32'(mem_addr_o), 32'(m_addr));
         chk(wr_valid_o == e_wr, e_tag, "wr_valid_o", 32'(wr_valid_o), 32'(e_wr));
         if (e_wr) begin
            chk(wr_code_o == e_code, e_tag, "wr_code_o", 32'(wr_code_o), 32'(e_code));
            chk(wr_data_o == e_data, e_tag, "wr_data_o", 32'(wr_data_o), 32'(e_data));
         end
         chk(illegal_o == e_ill, i_tag, "illegal_o", 32'(illegal_o), 32'(e_ill));
         chk(halted_o == (m_st == M_HALT), "R8", "halted_o", 32'(halted_o), 32'(m_st == M_HALT));
         chk(!(fetch_req_o && mem_req_o), "R11", "both requests", 32'(fetch_req_o && mem_req_o), 32'd0);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (ack_mode) begin
         fetch_ack_i = 1'b1;
         mem_ack_i   = 1'b1;
      end else begin
         fetch_ack_i = lfsr[0] | lfsr[5];
         mem_ack_i   = lfsr[3] & lfsr[9];
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic reset_checks();
      // R1: reset state at the ports
      chk(fetch_req_o == 1'b1, "R1", "fetch_req_o", 32'(fetch_req_o), 32'd1);
      chk(fetch_addr_o == 16'h0000, "R1", "fetch_addr_o", 32'(fetch_addr_o), 32'd0);
      chk(!mem_req_o && !wr_valid_o, "R1", "mem_req/wr_valid", 32'({mem_req_o, wr_valid_o}), 32'd0);
      chk(!illegal_o && !halted_o, "R1", "illegal/halted", 32'({illegal_o, halted_o}), 32'd0);
   endtask

   task automatic log_checks();
      logic [15:0] exp_ma [6];
      exp_ma = '{16'h8007, 16'h8007, 16'h1235, 16'h1220, 16'h0008, 16'hFF78};
      chk(ma_log.size() == 6, "R5", "memory read count", 32'(ma_log.size()), 32'd6);
      for (int i = 0; i < 6 && i < ma_log.size(); i++)
         chk(ma_log[i] == exp_ma[i], (i < 2) ? "R4" : "R5", "read address",
             32'(ma_log[i]), 32'(exp_ma[i]));
      chk(wr_log.size() == 18, "R9", "write count", 32'(wr_log.size()), 32'd18);
      if (wr_log.size() == 18) begin
         // R1: ld b,c straight after reset copies zero
         chk(wr_log[0] == {3'b000, 8'h00}, "R1", "first write", 32'(wr_log[0]), 32'({3'b000, 8'h00}));
         chk(wr_log[1] == {3'b111, 8'h5C}, "R3", "ld a,5C", 32'(wr_log[1]), 32'({3'b111, 8'h5C}));
         chk(wr_log[8] == {3'b111, 8'h11}, "R2", "ld a,b", 32'(wr_log[8]), 32'({3'b111, 8'h11}));
         chk(wr_log[9] == {3'b001, 8'h11}, "R2", "ld c,a", 32'(wr_log[9]), 32'({3'b001, 8'h11}));
         chk(wr_log[17] == {3'b100, memf(16'hFF78)}, "R2", "ld h,l",
             32'(wr_log[17]), 32'({3'b100, memf(16'hFF78)}));
      end
      // R8: fetching stopped just after the stop byte at 43
      chk(fetch_addr_o == 16'd44 && halted_o, "R8", "halt address", 32'(fetch_addr_o), 32'd44);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) prog[i] = 8'hFF;
      prog[0]  = 8'h00;                    // R7 nop
      prog[1]  = 8'h41;                    // ld b,c
      prog[2]  = 8'h3E; prog[3]  = 8'h5C;  // R3 immediates
      prog[4]  = 8'h06; prog[5]  = 8'h11;
      prog[6]  = 8'h0E; prog[7]  = 8'h22;
      prog[8]  = 8'h16; prog[9]  = 8'h33;
      prog[10] = 8'h1E; prog[11] = 8'h44;
      prog[12] = 8'h26; prog[13] = 8'h80;
      prog[14] = 8'h2E; prog[15] = 8'h07;
      prog[16] = 8'h78;                    // R2 ld a,b
      prog[17] = 8'h4F;                    // ld c,a
      prog[18] = 8'h7E;                    // R4 ld a,(hl)
      prog[19] = 8'h46;                    // ld b,(hl)
      prog[20] = 8'hDD; prog[21] = 8'h7E; prog[22] = 8'h05;  // R5 base X +5
      prog[23] = 8'hDD; prog[24] = 8'h56; prog[25] = 8'hF0;  // base X -16
      prog[26] = 8'hFD; prog[27] = 8'h66; prog[28] = 8'h10;  // base Y wraps
      prog[29] = 8'hFD; prog[30] = 8'h6E; prog[31] = 8'h80;  // base Y -128
      prog[32] = 8'h36;                    // R9 illegal
      prog[33] = 8'h70;
      prog[34] = 8'hC3;
      prog[35] = 8'hDD; prog[36] = 8'h78;  // R10 bad follower
      prog[37] = 8'hFD; prog[38] = 8'h76;
      prog[39] = 8'hDD; prog[40] = 8'hDD;
      prog[41] = 8'h7D;                    // ld a,l
      prog[42] = 8'h65;                    // ld h,l
      prog[43] = 8'h76;                    // R8 stop
      prog[44] = 8'h3E; prog[45] = 8'hFF;

      // phase 1: random stalls
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      reset_checks();
      chk_en = 1'b1;
      wait (halted_o === 1'b1);
      repeat (20) @(posedge clk);
      #1 log_checks();

      // phase 2: reset again, no stalls
      rst_n = 1'b0; chk_en = 1'b0; ack_mode = 1'b1;
      repeat (2) @(posedge clk);
      ma_log.delete(); wr_log.delete();
      #1 rst_n = 1'b1;
      reset_checks();
      chk_en = 1'b1;
      wait (halted_o === 1'b1);
      repeat (10) @(posedge clk);
      #1 log_checks();

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule